// File: doc/BRIEF.md
# SMBus host block data buffer

This block is the data path between the byte-wide host register port of an SMBus host controller and the transaction engine that shifts bytes on the wire. It handles the payload of block writes and block reads. The engine is reduced here to a byte handshake. Outbound bytes move on `tx_valid`/`tx_ready`, and inbound bytes move on `rx_valid`/`rx_ready`. Address, command and wire-level timing stay in the engine.

A mode bit selects one of two behaviours for the single data register.

- **Array mode.** The data register is a window onto a 32-byte store. A host index steps on every data access and returns to zero whenever software reads the control register. Engine traffic always starts at entry 0 and moves in chunks of up to 32 bytes.
- **Mailbox mode.** The data register holds exactly one byte. Every byte moved by the engine raises the done flag.

When a chunk ends, the done flag is set. The flag is cleared by writing one to it. While it is set in the middle of a transfer, the block holds the bus with a stretch request. An interrupt follows the done flag when interrupts are enabled.

Top module: `smb_blkdata_buf`

Register map (host_addr):
- 0 = status: bit0 done (write 1 clears), bit1 active.
- 1 = control: bit0 irq enable, bit1 array mode, bit2 read direction, bit3 start (write only, reads 0). Reading address 1 resets the host index.
- 2 = byte count / received count.
- 3 = data.

## Requirements
- R1: After reset, all four host registers read 00h, and irq, stretch, tx_valid and rx_ready are low.
- R2: In array mode, each host read or write of address 3 accesses the entry at the host index, and the index then advances by one. Any host read of address 1 sets the index to 0.
- R3: The host index saturates after 32 accesses. Further data writes change nothing, and further data reads return entry 31.
- R4: A start written to control bit3 with bit2=0 begins a write. The engine is offered data bytes in order, one per `tx_valid && tx_ready`. In array mode the bytes come from entries 0,1,2…. The byte count register value appears on `eng_count`.
- R5: A start with bit2=1 begins a read. The first received byte is stored in the count register (address 2). The following bytes fill the array from entry 0, or the data register in mailbox mode. Done is set once that many bytes have arrived. A received count of 0 ends the read at once.
- R6: In array mode, when 32 bytes have moved and the count is not exhausted, done is set and stretch is raised. No byte is moved until done is cleared, and the transfer then resumes at entry 0.
- R7: In mailbox mode, a write sends the data register contents for each byte. After every byte, done is set and the next byte waits, with stretch high, until software clears done.
- R8: In mailbox mode, a read places each received byte into the data register and sets done. No further byte is accepted until done is cleared.
- R9: Writing status with bit0=1 clears done. Writing bit0=0 leaves it unchanged.
- R10: irq is high exactly while done is set and the irq enable bit is set.
- R11: `eng_data1` always shows the mailbox data register.
- R12: While a transfer is active, a start, a mode or direction change and a count write are ignored. A write start with a count of 0 sets done on the next cycle and moves no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe (side effects only) |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| tx_valid | output | 1 | Outbound byte available |
| tx_data | output | 8 | Outbound byte |
| tx_ready | input | 1 | Engine takes the outbound byte |
| rx_valid | input | 1 | Engine offers an inbound byte |
| rx_data | input | 8 | Inbound byte |
| rx_ready | output | 1 | Block accepts the inbound byte |
| stretch | output | 1 | Hold the bus: software must service the buffer |
| irq | output | 1 | Level completion interrupt |
| eng_count | output | 8 | Byte count for the engine to transmit |
| eng_data1 | output | 8 | Single data byte for one-byte commands |

## Verification
A wrong engine position shows on `tx_data` in the same cycle that `tx_valid` rises. A wrong position on the read side shows on the next host data read. A wrong host index shows on the first `host_rdata` of a data read. A stale or spurious done flag shows on `stretch`, `irq` and the handshake lines one cycle after the byte that should or should not have set it. The bench runs a behavioural model alongside the design and compares every output on every clock, so any such divergence is reported within a cycle of its first port-visible effect. Directed checks pin down the chunk boundary at 32, the index saturation and the handshake pause.

// File: rtl/smb_blkdata_buf.sv
module smb_blkdata_buf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_ready,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          stretch,
  output logic          irq,
  output logic [DW-1:0] eng_count,
  output logic [DW-1:0] eng_data1
);
  localparam int PW = $clog2(DEPTH);
  localparam int IW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] HMAX  = IW'(DEPTH);
  localparam logic [PW-1:0] ELAST = PW'(DEPTH - 1);
  localparam logic [1:0] A_STAT = 2'd0, A_CTRL = 2'd1, A_CNT = 2'd2, A_DATA = 2'd3;

  logic          done, active, dir_rd, arr_mode, irq_en, cnt_phase;
  logic [DW-1:0] cnt_reg, rem, mbox;
  logic [PW-1:0] eidx;
  logic [IW-1:0] hidx;
  logic [DW-1:0] mem [DEPTH];

  wire wr_stat = host_wr && host_addr == A_STAT;
  wire wr_ctrl = host_wr && host_addr == A_CTRL;
  wire wr_cnt  = host_wr && host_addr == A_CNT;
  wire wr_data = host_wr && host_addr == A_DATA;
  wire rd_ctrl = host_rd && host_addr == A_CTRL;
  wire rd_data = host_rd && host_addr == A_DATA;
  wire start   = wr_ctrl && host_wdata[3] && !active;

  wire [PW-1:0] rd_idx = (hidx == HMAX) ? ELAST : hidx[PW-1:0];
  wire chunk_end = arr_mode ? (eidx == ELAST) : 1'b1;

  assign tx_valid  = active && !dir_rd && !done;
  assign rx_ready  = active && dir_rd && !done;
  assign tx_data   = arr_mode ? mem[eidx] : mbox;
  assign stretch   = active && done;
  assign irq       = done && irq_en;
  assign eng_count = cnt_reg;
  assign eng_data1 = mbox;

  wire tx_fire   = tx_valid && tx_ready;
  wire rx_fire   = rx_valid && rx_ready;
  wire data_fire = tx_fire || (rx_fire && !cnt_phase);

  always_comb begin
    case (host_addr)
      A_STAT:  host_rdata = {{(DW-2){1'b0}}, active, done};
      A_CTRL:  host_rdata = {{(DW-3){1'b0}}, dir_rd, arr_mode, irq_en};
      A_CNT:   host_rdata = cnt_reg;
      default: host_rdata = arr_mode ? mem[rd_idx] : mbox;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; active <= 1'b0; dir_rd <= 1'b0; arr_mode <= 1'b0;
      irq_en <= 1'b0; cnt_phase <= 1'b0;
      cnt_reg <= '0; rem <= '0; mbox <= '0; eidx <= '0; hidx <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (wr_ctrl) begin
        irq_en <= host_wdata[0];
        if (!active) begin
          arr_mode <= host_wdata[1];
          dir_rd   <= host_wdata[2];
        end
      end
      if (wr_cnt && !active) cnt_reg <= host_wdata;
      if (wr_stat && host_wdata[0]) done <= 1'b0;

      if (start) begin
        eidx      <= '0;
        rem       <= cnt_reg;
        cnt_phase <= host_wdata[2];
        if (!host_wdata[2] && cnt_reg == '0) done <= 1'b1;
        else begin
          active <= 1'b1;
          done   <= 1'b0;
        end
      end

      if (rd_ctrl) hidx <= '0;
      else if ((rd_data || wr_data) && arr_mode && hidx != HMAX) hidx <= hidx + 1'b1;

      if (wr_data) begin
        if (!arr_mode) mbox <= host_wdata;
        else if (hidx != HMAX) mem[hidx[PW-1:0]] <= host_wdata;
      end

      if (rx_fire && cnt_phase) begin
        cnt_reg   <= rx_data;
        rem       <= rx_data;
        cnt_phase <= 1'b0;
        if (rx_data == '0) begin
          done   <= 1'b1;
          active <= 1'b0;
        end
      end

      if (rx_fire && !cnt_phase) begin
        if (arr_mode) mem[eidx] <= rx_data;
        else mbox <= rx_data;
      end

      if (data_fire) begin
        rem <= rem - DW'(1);
        if (rem == DW'(1)) begin
          done   <= 1'b1;
          active <= 1'b0;
          eidx   <= '0;
        end else if (chunk_end) begin
          done <= 1'b1;
          eidx <= '0;
        end else begin
          eidx <= eidx + 1'b1;
        end
      end
    end
  end

  assert_no_move_while_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stretch |-> (!tx_valid && !rx_ready));

  assert_index_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> (hidx == '0));

  assert_mailbox_pause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !arr_mode) |=> done);

  assert_done_clear_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> ($past(wr_stat && host_wdata[0]) || $past(start)));

  assert_count_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && cnt_phase) |=> (eng_count == $past(rx_data)));
endmodule

// File: tb/smb_blkdata_buf_tb.sv
`timescale 1ns/1ps
module smb_blkdata_buf_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata, tx_data, rx_data = 0, eng_count, eng_data1;
  logic tx_valid, tx_ready = 0, rx_valid = 0, rx_ready, stretch, irq;

  always #2.5 clk = ~clk;

  smb_blkdata_buf dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .stretch(stretch), .irq(irq), .eng_count(eng_count), .eng_data1(eng_data1));

  int total = 0, bad = 0;
  bit run = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // behavioural reference
  bit m_done, m_act, m_rd, m_arr, m_ien, m_cph;
  int m_cnt, m_rem, m_pos, m_hptr, m_mbox;
  int m_mem[32];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_done = 0; m_act = 0; m_rd = 0; m_arr = 0; m_ien = 0; m_cph = 0;
      m_cnt = 0; m_rem = 0; m_pos = 0; m_hptr = 0; m_mbox = 0;
      foreach (m_mem[k]) m_mem[k] = 0;
    end else begin
      bit txf, rxf, o_act, o_arr, o_cph;
      int o_rem, o_pos, o_hptr;
      txf = m_act && !m_rd && !m_done && tx_ready;
      rxf = m_act && m_rd && !m_done && rx_valid;
      o_act = m_act; o_arr = m_arr; o_cph = m_cph;
      o_rem = m_rem; o_pos = m_pos; o_hptr = m_hptr;
      if (host_wr) begin
        case (host_addr)
          2'd0: if (host_wdata[0]) m_done = 0;
          2'd1: begin
            m_ien = host_wdata[0];
            if (!o_act) begin
              m_arr = host_wdata[1];
              m_rd  = host_wdata[2];
              if (host_wdata[3]) begin
                m_pos = 0; m_rem = m_cnt; m_cph = host_wdata[2];
                if (!host_wdata[2] && m_cnt == 0) m_done = 1;
                else begin m_act = 1; m_done = 0; end
              end
            end
          end
          2'd2: if (!o_act) m_cnt = host_wdata;
          default: if (!o_arr) m_mbox = host_wdata;
                   else if (o_hptr < 32) m_mem[o_hptr] = host_wdata;
        endcase
      end
      if (host_rd && host_addr == 2'd1) m_hptr = 0;
      else if ((host_rd || host_wr) && host_addr == 2'd3 && o_arr && o_hptr < 32) m_hptr = o_hptr + 1;
      if (rxf && o_cph) begin
        m_cnt = rx_data; m_rem = rx_data; m_cph = 0;
        if (rx_data == 0) begin m_done = 1; m_act = 0; end
      end
      if (txf || (rxf && !o_cph)) begin
        if (rxf) begin
          if (o_arr) m_mem[o_pos] = rx_data; else m_mbox = rx_data;
        end
        m_rem = o_rem - 1;
        if (o_rem == 1) begin m_done = 1; m_act = 0; m_pos = 0; end
        else if (!o_arr || o_pos == 31) begin m_done = 1; m_pos = 0; end
        else m_pos = o_pos + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run) begin
      bit etx;
      int erd;
      etx = m_act && !m_rd && !m_done;
      chk("R4 tx_valid", tx_valid, etx);
      if (etx) chk("R4 tx_data", tx_data, m_arr ? m_mem[m_pos] : m_mbox);
      chk("R5 rx_ready", rx_ready, m_act && m_rd && !m_done);
      chk("R6 stretch", stretch, m_act && m_done);
      chk("R10 irq", irq, m_done && m_ien);
      chk("R11 eng_data1", eng_data1, m_mbox);
      chk("R4 eng_count", eng_count, m_cnt);
      case (host_addr)
        2'd0: erd = {m_act, m_done};
        2'd1: erd = {m_rd, m_arr, m_ien};
        2'd2: erd = m_cnt;
        default: erd = !m_arr ? m_mbox : m_mem[m_hptr > 31 ? 31 : m_hptr];
      endcase
      chk("R2 host_rdata", host_rdata, erd);
    end
  end

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) txq.push_back(tx_data);
    if (rst_n && rx_valid && rx_ready) void'(rxq.pop_front());
  end

  always @(negedge clk) begin
    #1;
    rx_valid = rxq.size() > 0;
    rx_data  = (rxq.size() > 0) ? rxq[0] : 8'h00;
  end

  task automatic hw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    host_wr = 1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 0; host_addr = 0; host_wdata = 0;
  endtask

  task automatic hr(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); #1;
    host_rd = 1; host_addr = a;
    #1 chk(tag, host_rdata, exp);
    @(posedge clk); #1;
    host_rd = 0; host_addr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1; run = 1;
    tx_ready = 1;
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 stretch", stretch, 0);
    chk("R1 tx_valid", tx_valid, 0); chk("R1 rx_ready", rx_ready, 0);
    for (int a = 0; a < 4; a++) hr(a[1:0], 8'h00, "R1 reg");

    // R2 R3 array fill and saturation
    hw(2'd1, 8'h03);
    for (int i = 0; i < 32; i++) hw(2'd3, 8'hA0 + i[7:0]);
    hw(2'd3, 8'hFF);
    hr(2'd1, 8'h03, "R2 ctrl");
    for (int i = 0; i < 32; i++) hr(2'd3, 8'hA0 + i[7:0], "R2 array read");
    hr(2'd3, 8'hBF, "R3 saturated read");
    hr(2'd3, 8'hBF, "R3 saturated read again");

    // R4 array write of 5 bytes
    txq.delete();
    hw(2'd2, 8'd5);
    hw(2'd1, 8'h0B);
    idle(10);
    chk("R4 byte count sent", txq.size(), 5);
    for (int i = 0; i < 5; i++) if (i < txq.size()) chk("R4 byte order", txq[i], 8'hA0 + i);
    chk("R10 irq on done", irq, 1);
    hw(2'd0, 8'h00);
    hr(2'd0, 8'h01, "R9 write zero keeps done");
    hw(2'd0, 8'h01);
    hr(2'd0, 8'h00, "R9 w1c clears done");
    chk("R10 irq after clear", irq, 0);

    // R6 chunk boundary with count 34
    txq.delete();
    hw(2'd2, 8'd34);
    hw(2'd1, 8'h0B);
    idle(40);
    chk("R6 first chunk size", txq.size(), 32);
    chk("R6 stretch held", stretch, 1);
    hr(2'd0, 8'h03, "R6 active and done");
    hr(2'd1, 8'h03, "R6 ctrl");
    hw(2'd3, 8'h11);
    hw(2'd3, 8'h22);
    hw(2'd0, 8'h01);
    idle(6);
    chk("R6 total bytes", txq.size(), 34);
    if (txq.size() == 34) begin
      chk("R6 entry 31", txq[31], 8'hBF);
      chk("R6 resume at 0", txq[32], 8'h11);
      chk("R6 resume at 1", txq[33], 8'h22);
    end
    chk("R6 stretch released", stretch, 0);
    hw(2'd0, 8'h01);

    // R5 array read
    rxq.push_back(8'd3); rxq.push_back(8'h5A); rxq.push_back(8'h6B); rxq.push_back(8'h7C);
    hw(2'd1, 8'h0F);
    idle(10);
    hr(2'd0, 8'h01, "R5 done after count");
    hr(2'd2, 8'h03, "R5 count captured");
    hr(2'd1, 8'h07, "R5 ctrl");
    hr(2'd3, 8'h5A, "R5 entry 0");
    hr(2'd3, 8'h6B, "R5 entry 1");
    hr(2'd3, 8'h7C, "R5 entry 2");
    hw(2'd0, 8'h01);

    // R7 R11 mailbox write
    txq.delete();
    hw(2'd1, 8'h00);
    hw(2'd3, 8'h3C);
    chk("R11 data1 mirrors", eng_data1, 8'h3C);
    hw(2'd2, 8'd2);
    hw(2'd1, 8'h08);
    idle(4);
    chk("R7 one byte then pause", txq.size(), 1);
    chk("R7 stretch", stretch, 1);
    chk("R10 irq masked", irq, 0);
    hw(2'd3, 8'h4D);
    hw(2'd0, 8'h01);
    idle(4);
    chk("R7 second byte", txq.size(), 2);
    if (txq.size() == 2) begin
      chk("R7 byte 0", txq[0], 8'h3C);
      chk("R7 byte 1", txq[1], 8'h4D);
    end
    chk("R7 stretch off at end", stretch, 0);
    hw(2'd0, 8'h01);

    // R8 mailbox read
    rxq.push_back(8'd2); rxq.push_back(8'h91); rxq.push_back(8'h92);
    hw(2'd1, 8'h0C);
    idle(6);
    chk("R8 stretch", stretch, 1);
    chk("R8 byte held back", rxq.size(), 1);
    hr(2'd3, 8'h91, "R8 first byte");
    hw(2'd0, 8'h01);
    idle(4);
    hr(2'd0, 8'h01, "R8 finished");
    hr(2'd3, 8'h92, "R8 second byte");
    hw(2'd0, 8'h01);

    // R12 start and mode ignored while active, zero count
    txq.delete();
    hw(2'd3, 8'h55);
    hw(2'd2, 8'd2);
    hw(2'd1, 8'h08);
    idle(4);
    hw(2'd1, 8'h0B);
    hw(2'd2, 8'd9);
    hr(2'd1, 8'h01, "R12 mode kept");
    hr(2'd2, 8'h02, "R12 count kept");
    chk("R12 irq enable applied", irq, 1);
    chk("R12 no restart", txq.size(), 1);
    hw(2'd3, 8'h66);
    hw(2'd0, 8'h01);
    idle(4);
    chk("R12 finished two", txq.size(), 2);
    hw(2'd0, 8'h01);
    hw(2'd2, 8'd0);
    hw(2'd1, 8'h08);
    idle(3);
    hr(2'd0, 8'h01, "R12 zero count done");
    chk("R12 zero count sends nothing", txq.size(), 2);
    chk("R12 no stretch", stretch, 0);

    idle(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule